// File: doc/BRIEF.md
# Interval-Gated Pipelined Execution Unit

This block is the timing skeleton of a pipelined SIMD execution unit. An instruction token (an opaque data word) arrives with two numbers: its total latency and its initiation interval. The unit keeps the token in a single dispatch slot until the interval has elapsed. It then drops the token into a shift-register pipeline at a stage picked so that the token still leaves after the full latency. Tokens shift one stage toward the output on every cycle and leave through a result port.

A bit vector records, for every outstanding token, the cycle on which it will leave. The vector shifts by one place per cycle. A new request whose exit cycle would match an outstanding token's exit cycle is held off, so two tokens never meet in the same stage. The result port can push back. While it does, the whole unit freezes: the pipeline, the countdown, the occupancy vector and issue acceptance all hold.

Top module: `pipe_eu`

## Requirements
- R1: After reset no result is presented (`res_valid`=0), `issue_err` is 0 and, for latency 0 and interval 0, `issue_ready` is 1.
- R2: A token accepted at a clock edge with latency L (3-bit `issue_lat`) and interval I (3-bit `issue_ii`) appears on `res_valid`/`res_data` right after the L+1-th following edge, with its data unchanged, whatever I is, when there is no backpressure. `res_valid` is low before that edge.
- R3: A request is legal only when I <= L and L-I < DEPTH (DEPTH = 4). For any other pair, `issue_err` is 1 and `issue_ready` is 0 in the same cycle, and the token never reaches the result port.
- R4: An accepted token sits in the dispatch slot for I+1 edges and then enters pipeline stage L-I. While the slot is occupied, `issue_ready` is 0.
- R5: When the dispatch slot is free, a request whose exit edge (acceptance edge + L + 1) equals the exit edge of a token already in flight sees `issue_ready` 0. Tokens with distinct exit edges are accepted and leave in exit order, one per cycle.
- R6: When `res_valid` and `res_full` are both 1, the result token and its data hold, `issue_ready` is 0 and every token behind it is delayed by exactly the number of stalled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request present |
| issue_lat | input | LAT_W | Total latency of the request |
| issue_ii | input | II_W | Initiation interval of the request |
| issue_data | input | DATA_W | Opaque token payload |
| issue_ready | output | 1 | Request would be accepted this cycle |
| issue_err | output | 1 | Request has an illegal latency/interval pair |
| res_valid | output | 1 | Token present at the result port |
| res_data | output | DATA_W | Payload of the token at the result port |
| res_full | input | 1 | Result port cannot take a token this cycle |

## Verification
The assertions assume that `issue_lat`, `issue_ii` and `issue_data` are steady around each clock edge, and that `res_full` can take any value. The stimulus changes inputs only on the falling edge and drops `issue_valid` right after an accepting edge. No checked sequence depends on a request left pending. Each directed case starts from an empty pipeline, so the timing the bench predicts comes only from the latency, interval and stall cycles of that case.

// File: rtl/pipe_eu_pkg.sv
package pipe_eu_pkg;

  // A latency/interval pair is legal when the entry stage exists.
  function automatic logic interval_fits(int unsigned lat, int unsigned ii,
                                         int unsigned depth);
    return (ii <= lat) && ((lat - ii) < depth);
  endfunction

  // Stage where a released token is placed.
  function automatic int unsigned entry_stage(int unsigned lat, int unsigned ii);
    return lat - ii;
  endfunction

endpackage

// File: rtl/eu_dispatch.sv
module eu_dispatch #(
  parameter int LAT_W  = 3,
  parameter int II_W   = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic [LAT_W-1:0]  load_lat,
  input  logic [II_W-1:0]   load_ii,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              release_now,
  output logic [II_W-1:0]   delay,
  output logic [LAT_W-1:0]  slot_lat,
  output logic [II_W-1:0]   slot_ii,
  output logic [DATA_W-1:0] slot_data
);

  assign release_now = busy && (delay == '0) && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      delay     <= '0;
      slot_lat  <= '0;
      slot_ii   <= '0;
      slot_data <= '0;
    end else if (!hold) begin
      if (release_now) begin
        busy <= 1'b0;
      end else if (busy) begin
        delay <= delay - 1'b1;
      end
      if (load) begin
        busy      <= 1'b1;
        delay     <= load_ii;
        slot_lat  <= load_lat;
        slot_ii   <= load_ii;
        slot_data <= load_data;
      end
    end
  end

endmodule

// File: rtl/eu_occupancy.sv
module eu_occupancy #(
  parameter int LAT_W = 3,
  localparam int OCC_W = 1 << LAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             mark,
  input  logic [LAT_W-1:0] mark_lat,
  output logic [OCC_W-1:0] occ,
  output logic [OCC_W-1:0] occ_ahead
);

  // View of the vector one cycle later, used for the exit-clash test.
  assign occ_ahead = occ >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else if (!hold) begin
      occ <= occ_ahead | (mark ? (OCC_W'(1) << mark_lat) : '0);
    end
  end

endmodule

// File: rtl/eu_shift_pipe.sv
module eu_shift_pipe #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              inj_en,
  input  logic [SW-1:0]     inj_stage,
  input  logic [DATA_W-1:0] inj_data,
  output logic [DEPTH-1:0]  stage_valid,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data
);

  logic [DATA_W-1:0] stage_data [DEPTH];

  assign head_valid = stage_valid[0];
  assign head_data  = stage_data[0];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic              up_valid;
    logic [DATA_W-1:0] up_data;
    logic              take_new;

    if (s + 1 < DEPTH) begin : g_mid
      assign up_valid = stage_valid[s+1];
      assign up_data  = stage_data[s+1];
    end else begin : g_top
      assign up_valid = 1'b0;
      assign up_data  = '0;
    end

    assign take_new = inj_en && (int'(inj_stage) == s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_valid[s] <= 1'b0;
        stage_data[s]  <= '0;
      end else if (!hold) begin
        stage_valid[s] <= take_new ? 1'b1 : up_valid;
        stage_data[s]  <= take_new ? inj_data : up_data;
      end
    end
  end

endmodule

// File: rtl/pipe_eu.sv
module pipe_eu #(
  parameter int DEPTH  = 4,
  parameter int LAT_W  = 3,
  parameter int II_W   = 3,
  parameter int DATA_W = 8,
  localparam int OCC_W = 1 << LAT_W,
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [LAT_W-1:0]  issue_lat,
  input  logic [II_W-1:0]   issue_ii,
  input  logic [DATA_W-1:0] issue_data,
  output logic              issue_ready,
  output logic              issue_err,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  input  logic              res_full
);
  import pipe_eu_pkg::*;

  // Named internal events
  logic              stall;
  logic              range_ok;
  logic              exit_clash;
  logic              accept;
  logic              disp_busy;
  logic              inj_fire;
  logic [II_W-1:0]   disp_delay;
  logic [LAT_W-1:0]  disp_lat;
  logic [II_W-1:0]   disp_ii;
  logic [DATA_W-1:0] disp_data;
  logic [SW-1:0]     inj_stage;
  logic [OCC_W-1:0]  occ_vec;
  logic [OCC_W-1:0]  occ_ahead;
  logic [DEPTH-1:0]  stage_valid;
  logic              head_valid;
  logic [DATA_W-1:0] head_data;

  assign stall       = head_valid && res_full;
  assign range_ok    = interval_fits(int'(issue_lat), int'(issue_ii), DEPTH);
  assign exit_clash  = occ_ahead[issue_lat];
  assign issue_ready = !stall && !disp_busy && !exit_clash && range_ok;
  assign issue_err   = issue_valid && !range_ok;
  assign accept      = issue_valid && issue_ready;
  assign inj_stage   = SW'(entry_stage(int'(disp_lat), int'(disp_ii)));
  assign res_valid   = head_valid;
  assign res_data    = head_data;

  eu_dispatch #(.LAT_W(LAT_W), .II_W(II_W), .DATA_W(DATA_W)) disp_u (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .load(accept), .load_lat(issue_lat), .load_ii(issue_ii), .load_data(issue_data),
    .busy(disp_busy), .release_now(inj_fire), .delay(disp_delay),
    .slot_lat(disp_lat), .slot_ii(disp_ii), .slot_data(disp_data)
  );

  eu_occupancy #(.LAT_W(LAT_W)) occ_u (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .mark(accept), .mark_lat(issue_lat),
    .occ(occ_vec), .occ_ahead(occ_ahead)
  );

  eu_shift_pipe #(.DEPTH(DEPTH), .DATA_W(DATA_W)) pipe_u (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .inj_en(inj_fire), .inj_stage(inj_stage), .inj_data(disp_data),
    .stage_valid(stage_valid), .head_valid(head_valid), .head_data(head_data)
  );

  // Stage just above the injection point, for the collision check.
  logic [DEPTH:0] valid_ext;
  logic           above_inj;
  assign valid_ext = {1'b0, stage_valid};
  assign above_inj = valid_ext[int'(inj_stage) + 1];

  assert_no_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |-> !above_inj);

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_full) |=> (res_valid && $stable(res_data)));

  assert_freeze_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(occ_vec));

  assert_load_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (disp_busy && disp_delay == $past(issue_ii)));

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_busy && disp_delay != '0 && !stall) |=>
      (disp_busy && disp_delay == $past(disp_delay) - 1'b1));

  assert_reject_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_err && !disp_busy) |=> !disp_busy);

endmodule

// File: tb/pipe_eu_tb_top.sv
`timescale 1ns/1ps
module pipe_eu_tb_top;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue_valid = 1'b0;
  logic [2:0] issue_lat = '0;
  logic [2:0] issue_ii = '0;
  logic [7:0] issue_data = '0;
  logic       issue_ready;
  logic       issue_err;
  logic       res_valid;
  logic [7:0] res_data;
  logic       res_full = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pipe_eu #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_lat(issue_lat),
    .issue_ii(issue_ii), .issue_data(issue_data), .issue_ready(issue_ready),
    .issue_err(issue_err), .res_valid(res_valid), .res_data(res_data),
    .res_full(res_full)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic set_req(input int lat, input int ii, input int data);
    issue_lat  = 3'(lat);
    issue_ii   = 3'(ii);
    issue_data = 8'(data);
    #0.1;
  endtask

  // Drive valid for exactly one edge.
  task automatic fire();
    issue_valid = 1'b1;
    @(posedge clk);
    #1 issue_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    set_req(0, 0, 0);
    check(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    check(issue_err == 1'b0, "R1 issue_err", int'(issue_err), 0);
    check(issue_ready == 1'b1, "R1 issue_ready", int'(issue_ready), 1);

    // R2/R3: sweep every latency/interval pair
    for (int lat = 0; lat < 8; lat++) begin
      for (int ii = 0; ii < 8; ii++) begin
        logic legal;
        int   d;
        legal = (ii <= lat) && ((lat - ii) < DEPTH);
        d = lat * 16 + ii + 1;
        @(negedge clk);
        set_req(lat, ii, d);
        issue_valid = 1'b1;
        #0.1;
        check(issue_err == !legal, "R3 err flag", int'(issue_err), int'(!legal));
        check(issue_ready == legal, "R3 ready", int'(issue_ready), int'(legal));
        @(posedge clk);
        #1 issue_valid = 1'b0;
        if (legal) begin
          repeat (lat) @(posedge clk);
          @(negedge clk);
          check(res_valid == 1'b0, "R2 early", int'(res_valid), 0);
          @(posedge clk);
          @(negedge clk);
          check(res_valid == 1'b1, "R2 arrival", int'(res_valid), 1);
          check(res_data == 8'(d), "R2 data", int'(res_data), d);
          @(posedge clk);
          @(negedge clk);
          check(res_valid == 1'b0, "R2 drained", int'(res_valid), 0);
        end else begin
          int seen;
          seen = 0;
          repeat (DEPTH + 10) begin
            @(negedge clk);
            if (res_valid) seen++;
          end
          check(seen == 0, "R3 never delivered", seen, 0);
        end
      end
    end

    // R4: slot busy for I+1 edges (lat 5, ii 3)
    @(negedge clk);
    set_req(5, 3, 8'hA5);
    fire();
    set_req(7, 4, 0); // probe that never clashes on exit
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(issue_ready == 1'b0, "R4 slot busy", int'(issue_ready), 0);
      @(posedge clk);
    end
    @(negedge clk);
    check(issue_ready == 1'b1, "R4 slot freed", int'(issue_ready), 1);
    // token accepted at edge t; now after edge t+4, exits after t+6
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(res_valid && res_data == 8'hA5, "R4 exit", int'(res_data), 8'hA5);
    repeat (4) @(posedge clk);

    // R5: exit-clash blocking
    @(negedge clk);
    set_req(3, 0, 8'h31);
    fire();                 // edge t
    @(posedge clk);         // t+1, slot freed
    @(negedge clk);
    set_req(1, 0, 8'h11);
    check(issue_ready == 1'b0, "R5 clash blocked", int'(issue_ready), 0);
    set_req(2, 0, 8'h22);
    check(issue_ready == 1'b1, "R5 distinct ok", int'(issue_ready), 1);
    fire();                 // t+2
    @(posedge clk);         // t+3
    @(posedge clk);         // t+4
    @(negedge clk);
    check(res_valid && res_data == 8'h31, "R5 first exit", int'(res_data), 8'h31);
    @(posedge clk);
    @(negedge clk);
    check(res_valid && res_data == 8'h22, "R5 second exit", int'(res_data), 8'h22);
    repeat (4) @(posedge clk);

    // R6: backpressure freezes the unit
    @(negedge clk);
    res_full = 1'b1;
    set_req(2, 0, 8'h5A);
    fire();                 // t
    @(posedge clk);         // t+1
    @(negedge clk);
    set_req(2, 0, 8'h6B);
    fire();                 // t+2
    @(posedge clk);         // t+3, A at stage 0
    @(negedge clk);
    check(res_valid && res_data == 8'h5A, "R6 head", int'(res_data), 8'h5A);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(res_valid && res_data == 8'h5A, "R6 held", int'(res_data), 8'h5A);
      check(issue_ready == 1'b0, "R6 no issue", int'(issue_ready), 0);
    end
    res_full = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(res_valid == 1'b0, "R6 gap", int'(res_valid), 0);
    @(posedge clk);
    @(negedge clk);
    check(res_valid && res_data == 8'h6B, "R6 follower", int'(res_data), 8'h6B);
    @(posedge clk);
    @(negedge clk);
    check(res_valid == 1'b0, "R6 empty", int'(res_valid), 0);

    report();
  end

endmodule